// File: doc/BRIEF.md
# PCM Highway Time-Slot Interface

This block ties four voice channels to one shared serial PCM highway. A single bit clock times all traffic and one frame sync marks the start of every frame for every channel. Each channel has its own transmit slot number and receive slot number. At frame start the block takes one parallel sample per channel and shifts it onto the serial line in that channel's slot. In the other direction it gathers the serial bits of each channel's receive slot into a parallel word and strobes it out.

Slot timing counts from an internal reference. That reference equals the frame-sync rising edge, or lags it by a programmed one to seven bit clocks. A frame-level mode bit picks 8-bit companded samples (one slot) or 16-bit linear samples (two neighbouring slots). A second bit picks the companding law. This law bit is latched and passed to the codec side unchanged, because companding arithmetic is outside this block. The transmit line comes with an output enable, so several devices can share the highway.

Top module: `pcm_highway_port`

## Requirements
- R1: A frame starts only on a rising edge of `fsync`, sampled on a rising `clk` edge. A sync one clock high (short) and a sync held high for several clocks (long) both start exactly one frame, and holding `fsync` high never restarts the frame.
- R2: With `sync_shift` = d (0..7), the MSB of slot 0 appears on `tx_data` after the rising edge that comes d edges after the edge that first samples `fsync` high.
- R3: Bit positions count from 0 at the internal reference. Slot k covers positions 8k to 8k+7. In companded mode a channel sends bits 7..0 of its sample, MSB first, and `tx_data` changes only after rising edges.
- R4: With the latched linear bit set, a channel sends all 16 bits MSB first over positions 8k to 8k+15, that is slots k and k+1.
- R5: Transmit samples are captured at the internal reference. Changing `tx_sample` later in the frame does not change that frame's serial data.
- R6: `cfg_linear` and `cfg_alaw` are latched at the internal reference and hold for the whole frame. `law_alaw` shows the latched law bit.
- R7: `tx_oe` is high exactly at positions inside some channel's transmit window, and `tx_data` is 0 whenever `tx_oe` is low.
- R8: `rx_data` is sampled on falling `clk` edges and shifted MSB first into each channel's receive window. On the rising edge after the falling edge that samples the window's last bit, `rx_sample` for that channel is updated and its `rx_valid` bit is high for one cycle. In companded mode the upper 8 bits of the word are zero.
- R9: When transmit windows overlap, only the lowest-numbered channel drives the line.
- R10: After reset `tx_oe`, `tx_data`, `rx_valid`, `rx_sample` and `law_alaw` are 0, and nothing is driven until the first frame sync.
- R11: Slot numbers run 0..127, so 128-slot frames are reachable. The position counter stops at its maximum rather than wrapping, so no slot repeats before the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, short or long |
| sync_shift | input | 3 | Delay of internal reference after frame sync, in bit clocks |
| cfg_linear | input | 1 | 1 = 16-bit linear samples, 0 = 8-bit companded samples |
| cfg_alaw | input | 1 | Companding law select, passed through |
| tx_slot | input | 28 | Per-channel transmit slot, 7 bits each, channel 0 in bits 6:0 |
| rx_slot | input | 28 | Per-channel receive slot, 7 bits each, channel 0 in bits 6:0 |
| tx_sample | input | 64 | Per-channel parallel transmit sample, 16 bits each |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit output enable (line released when low) |
| rx_data | input | 1 | Serial receive data |
| rx_sample | output | 64 | Per-channel received sample, 16 bits each |
| rx_valid | output | 4 | Per-channel one-cycle strobe for a new received sample |
| law_alaw | output | 1 | Latched companding law for the current frame |

## Verification
The bench builds the block with its default of four channels, 7-bit slot numbers and an 11-bit position counter. With these values it can reach 24-, 32- and 128-slot frames, slot 127 at the very end of a long frame, and every sync delay from 0 to 7. Four lanes are enough to set up deliberate overlaps of both companded and linear windows. Random frames mix sync lengths, delays, modes and changes to the inputs partway through a frame, and a bit-level model of the line checks every position of every frame.

// File: rtl/pcm_hw_pkg.sv
`timescale 1ns/1ps
package pcm_hw_pkg;
    localparam int SLOT_W        = 7;
    localparam int SLOT_SH       = 3;
    localparam int BITS_PER_SLOT = 1 << SLOT_SH;
    localparam int POS_W         = SLOT_W + SLOT_SH + 1;
    localparam int SAMP_W        = 2 * BITS_PER_SLOT;
    localparam int OFF_W         = SLOT_SH + 1;
    localparam int DLY_W         = 3;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [SAMP_W-1:0] samp_t;

    typedef struct packed {
        logic             hit;
        logic [OFF_W-1:0] off;
    } win_t;

    typedef struct packed {
        logic linear;
        logic alaw;
    } mode_t;

    // Decide whether a bit position falls in a slot window; give the offset inside it
    function automatic win_t slot_window(pos_t pos, slot_t slot, logic lin);
        pos_t base;
        pos_t diff;
        pos_t span;
        win_t w;
        base  = pos_t'(slot) << SLOT_SH;
        diff  = pos - base;
        span  = lin ? pos_t'(SAMP_W) : pos_t'(BITS_PER_SLOT);
        w.hit = (pos >= base) && (diff < span);
        w.off = diff[OFF_W-1:0];
        return w;
    endfunction

    // Serial bit for a given offset, MSB first
    function automatic logic pick_bit(samp_t s, logic [OFF_W-1:0] off, logic lin);
        int idx;
        idx = lin ? (SAMP_W - 1 - int'(off)) : (BITS_PER_SLOT - 1 - int'(off[SLOT_SH-1:0]));
        return s[idx];
    endfunction
endpackage

// File: rtl/pcm_frame_timer.sv
`timescale 1ns/1ps
module pcm_frame_timer
    import pcm_hw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fsync,
    input  logic [DLY_W-1:0] sync_shift,
    input  logic             cfg_linear,
    input  logic             cfg_alaw,
    output logic             isync,
    output pos_t             pos,
    output logic             frame_ok,
    output pos_t             nxt_pos,
    output logic             nxt_ok,
    output logic             nxt_lin,
    output mode_t            mode_q
);
    localparam int DLY_MAX = (1 << DLY_W) - 1;

    logic               fs_q;
    logic               fs_rise;
    logic [DLY_MAX:1]   dly;
    logic [DLY_MAX:0]   taps;

    assign fs_rise = fsync & ~fs_q;
    assign taps    = {dly, fs_rise};
    assign isync   = taps[sync_shift];

    assign nxt_pos = isync ? '0 : ((&pos) ? pos : pos + 1'b1);
    assign nxt_ok  = isync | frame_ok;
    assign nxt_lin = isync ? cfg_linear : mode_q.linear;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q     <= 1'b0;
            dly      <= '0;
            pos      <= '1;
            frame_ok <= 1'b0;
            mode_q   <= '0;
        end else begin
            fs_q     <= fsync;
            dly      <= {dly[DLY_MAX-1:1], fs_rise};
            pos      <= nxt_pos;
            frame_ok <= nxt_ok;
            if (isync) begin
                mode_q.linear <= cfg_linear;
                mode_q.alaw   <= cfg_alaw;
            end
        end
    end

    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        isync |=> (pos == '0) && frame_ok);

    p_count_up_r11: assert property (@(posedge clk) disable iff (rst)
        (!isync && frame_ok && !(&pos)) |=> (pos == $past(pos) + 1'b1));

    p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !isync |=> $stable(mode_q));
endmodule

// File: rtl/pcm_tx_lane.sv
`timescale 1ns/1ps
module pcm_tx_lane
    import pcm_hw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  isync,
    input  pos_t  nxt_pos,
    input  logic  nxt_ok,
    input  logic  nxt_lin,
    input  slot_t slot,
    input  samp_t sample_in,
    output logic  req,
    output logic  dbit
);
    samp_t held;
    samp_t src;
    win_t  w;

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else if (isync) held <= sample_in;
    end

    assign src  = isync ? sample_in : held;
    assign w    = slot_window(nxt_pos, slot, nxt_lin);
    assign req  = nxt_ok & w.hit;
    assign dbit = pick_bit(src, w.off, nxt_lin);

    p_hold_sample_r5: assert property (@(posedge clk) disable iff (rst)
        !isync |=> $stable(held));
endmodule

// File: rtl/pcm_rx_lane.sv
`timescale 1ns/1ps
module pcm_rx_lane
    import pcm_hw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pos_t  pos,
    input  logic  frame_ok,
    input  logic  lin,
    input  slot_t slot,
    input  logic  rx_bit,
    output samp_t sample,
    output logic  valid
);
    samp_t shreg;
    win_t  w;
    logic  last;

    assign w    = slot_window(pos, slot, lin);
    assign last = w.off == (lin ? OFF_W'(SAMP_W - 1) : OFF_W'(BITS_PER_SLOT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            sample <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (frame_ok && w.hit) begin
                shreg <= {shreg[SAMP_W-2:0], rx_bit};
                if (last) begin
                    sample <= lin ? {shreg[SAMP_W-2:0], rx_bit}
                                  : {{(SAMP_W-BITS_PER_SLOT){1'b0}},
                                     shreg[BITS_PER_SLOT-2:0], rx_bit};
                    valid  <= 1'b1;
                end
            end
        end
    end

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    p_valid_framed_r8: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(frame_ok));

    p_sample_steady_r8: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(sample));
endmodule

// File: rtl/pcm_highway_port.sv
`timescale 1ns/1ps
module pcm_highway_port
    import pcm_hw_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fsync,
    input  logic [DLY_W-1:0]         sync_shift,
    input  logic                     cfg_linear,
    input  logic                     cfg_alaw,
    input  logic [N_CH*SLOT_W-1:0]   tx_slot,
    input  logic [N_CH*SLOT_W-1:0]   rx_slot,
    input  logic [N_CH*SAMP_W-1:0]   tx_sample,
    output logic                     tx_data,
    output logic                     tx_oe,
    input  logic                     rx_data,
    output logic [N_CH*SAMP_W-1:0]   rx_sample,
    output logic [N_CH-1:0]          rx_valid,
    output logic                     law_alaw
);
    logic  isync;
    pos_t  pos;
    logic  frame_ok;
    pos_t  nxt_pos;
    logic  nxt_ok;
    logic  nxt_lin;
    mode_t mode_q;
    logic  rx_neg;

    logic [N_CH-1:0] req;
    logic [N_CH-1:0] dbit;
    logic            any_req;
    logic            sel_bit;

    pcm_frame_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .fsync      (fsync),
        .sync_shift (sync_shift),
        .cfg_linear (cfg_linear),
        .cfg_alaw   (cfg_alaw),
        .isync      (isync),
        .pos        (pos),
        .frame_ok   (frame_ok),
        .nxt_pos    (nxt_pos),
        .nxt_ok     (nxt_ok),
        .nxt_lin    (nxt_lin),
        .mode_q     (mode_q)
    );

    // Receive data is taken on the falling edge, half a bit after launch
    always_ff @(negedge clk) rx_neg <= rx_data;

    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        pcm_tx_lane u_tx (
            .clk       (clk),
            .rst       (rst),
            .isync     (isync),
            .nxt_pos   (nxt_pos),
            .nxt_ok    (nxt_ok),
            .nxt_lin   (nxt_lin),
            .slot      (tx_slot[g*SLOT_W +: SLOT_W]),
            .sample_in (tx_sample[g*SAMP_W +: SAMP_W]),
            .req       (req[g]),
            .dbit      (dbit[g])
        );
        pcm_rx_lane u_rx (
            .clk      (clk),
            .rst      (rst),
            .pos      (pos),
            .frame_ok (frame_ok),
            .lin      (mode_q.linear),
            .slot     (rx_slot[g*SLOT_W +: SLOT_W]),
            .rx_bit   (rx_neg),
            .sample   (rx_sample[g*SAMP_W +: SAMP_W]),
            .valid    (rx_valid[g])
        );
    end

    // Fixed priority: the lowest channel index owns a contested position
    always_comb begin
        any_req = 1'b0;
        sel_bit = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (req[i] && !any_req) begin
                any_req = 1'b1;
                sel_bit = dbit[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_oe   <= 1'b0;
            tx_data <= 1'b0;
        end else begin
            tx_oe   <= any_req;
            tx_data <= any_req & sel_bit;
        end
    end

    assign law_alaw = mode_q.alaw;

    p_low_wins_r9: assert property (@(posedge clk) disable iff (rst)
        req[0] |=> tx_oe && (tx_data == $past(dbit[0])));

    p_oe_framed_r7: assert property (@(posedge clk) disable iff (rst)
        tx_oe |-> frame_ok);

    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |-> !tx_data);

    p_quiet_before_sync_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_ok |-> (rx_valid == '0));
endmodule

// File: tb/pcm_highway_port_test.sv
`timescale 1ns/1ps
module pcm_highway_port_test;
    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            fsync = 1'b0;
    logic [2:0]      sync_shift = '0;
    logic            cfg_linear = 1'b0;
    logic            cfg_alaw = 1'b0;
    logic [NCH*7-1:0]  tx_slot = '0;
    logic [NCH*7-1:0]  rx_slot = '0;
    logic [NCH*16-1:0] tx_sample = '0;
    logic            tx_data;
    logic            tx_oe;
    logic            rx_data = 1'b0;
    logic [NCH*16-1:0] rx_sample;
    logic [NCH-1:0]  rx_valid;
    logic            law_alaw;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int       fr_txs [NCH];
    int       fr_rxs [NCH];
    bit [15:0] fr_samp [NCH];
    bit       fr_lin;
    bit       fr_alaw;
    bit       rxbits [0:1039];

    always #5 clk = ~clk;

    pcm_highway_port #(.N_CH(NCH)) uut (
        .clk(clk), .rst(rst), .fsync(fsync), .sync_shift(sync_shift),
        .cfg_linear(cfg_linear), .cfg_alaw(cfg_alaw),
        .tx_slot(tx_slot), .rx_slot(rx_slot), .tx_sample(tx_sample),
        .tx_data(tx_data), .tx_oe(tx_oe), .rx_data(rx_data),
        .rx_sample(rx_sample), .rx_valid(rx_valid), .law_alaw(law_alaw)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // Line model: lowest channel whose window covers position p drives it
    function automatic void exp_tx(input int p, output bit oe, output bit d);
        int base, len, off;
        oe = 0; d = 0;
        len = fr_lin ? 16 : 8;
        for (int ch = 0; ch < NCH; ch++) begin
            base = fr_txs[ch] * 8;
            if (!oe && p >= base && p < base + len) begin
                oe  = 1;
                off = p - base;
                d   = fr_lin ? fr_samp[ch][15-off] : fr_samp[ch][7-off];
            end
        end
    endfunction

    function automatic int rx_last(input int ch);
        return fr_rxs[ch] * 8 + (fr_lin ? 15 : 7);
    endfunction

    function automatic bit [15:0] exp_rx(input int ch);
        bit [15:0] v = '0;
        int n = fr_lin ? 16 : 8;
        for (int i = 0; i < n; i++) v = {v[14:0], rxbits[fr_rxs[ch]*8 + i]};
        return v;
    endfunction

    // Apply the frame's settings at a falling edge, then raise the sync
    task automatic setup(input int d, input bit lin, input bit alaw);
        fr_lin  = lin;
        fr_alaw = alaw;
        sync_shift = 3'(d);
        cfg_linear = lin;
        cfg_alaw   = alaw;
        for (int ch = 0; ch < NCH; ch++) begin
            tx_slot[ch*7 +: 7]     = 7'(fr_txs[ch]);
            rx_slot[ch*7 +: 7]     = 7'(fr_rxs[ch]);
            tx_sample[ch*16 +: 16] = fr_samp[ch];
        end
        for (int i = 0; i < 1040; i++) rxbits[i] = 1'($urandom);
    endtask

    task automatic run_frame(input string tag, input int d, input int fslen,
                             input int nbits, input bit mid_change);
        bit eo, ed, ev;
        int p;
        @(negedge clk);
        fsync = 1'b1;
        for (int k = 0; k <= d + nbits + 1; k++) begin
            @(posedge clk);
            #1;
            if (k == fslen - 1) fsync = 1'b0;
            p = k - d;
            rx_data = (p >= 0 && p < 1040) ? rxbits[p] : 1'b0;
            if (mid_change && k == d + 3) begin
                tx_sample  = {$urandom, $urandom};
                cfg_linear = ~cfg_linear;
                cfg_alaw   = ~cfg_alaw;
            end
            @(negedge clk);
            if (p >= 0) begin
                exp_tx(p, eo, ed);
                chk($sformatf("%s R7 oe p=%0d", tag, p), 32'(tx_oe), 32'(eo));
                chk($sformatf("%s %s data p=%0d", tag, fr_lin ? "R4" : "R3", p),
                    32'(tx_data), 32'(ed));
                if (p == 0 || p == nbits - 1)
                    chk($sformatf("%s R6 law p=%0d", tag, p), 32'(law_alaw), 32'(fr_alaw));
                for (int ch = 0; ch < NCH; ch++) begin
                    ev = (p - 1 == rx_last(ch));
                    chk($sformatf("%s R8 valid ch%0d p=%0d", tag, ch, p),
                        32'(rx_valid[ch]), 32'(ev));
                    if (ev)
                        chk($sformatf("%s R8 sample ch%0d", tag, ch),
                            32'(rx_sample[ch*16 +: 16]), 32'(exp_rx(ch)));
                end
            end
        end
    endtask

    task automatic rand_slots(input int nslots, input bit lin);
        int mx = lin ? nslots - 2 : nslots - 1;
        for (int ch = 0; ch < NCH; ch++) begin
            fr_txs[ch]  = $urandom_range(mx, 0);
            fr_rxs[ch]  = $urandom_range(mx, 0);
            fr_samp[ch] = 16'($urandom);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d, fl, ns;
        bit lin;
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state and silence without a frame sync
        chk("R10 oe after reset", 32'(tx_oe), 0);
        chk("R10 data after reset", 32'(tx_data), 0);
        chk("R10 valid after reset", 32'(rx_valid), 0);
        chk("R10 sample after reset", rx_sample[31:0], 0);
        chk("R10 law after reset", 32'(law_alaw), 0);
        fr_txs = '{0, 3, 9, 20};
        fr_rxs = '{1, 4, 12, 31};
        fr_samp = '{16'hA5C3, 16'h0F81, 16'h7E18, 16'hFFFF};
        setup(0, 0, 1);
        rx_data = 1'b1;
        repeat (12) begin
            @(negedge clk);
            chk("R10 no drive before sync", 32'(tx_oe), 0);
            chk("R10 no valid before sync", 32'(rx_valid), 0);
        end
        // R1 R2: short sync, no delay
        run_frame("R1 short", 0, 1, 256, 0);
        // R2: maximum delay with a long sync
        fr_samp = '{16'h1234, 16'h8001, 16'hC3C3, 16'h5AA5};
        setup(7, 1, 0);
        run_frame("R2 d7 long", 7, 5, 256, 0);
        // R9: overlapping windows, companded then linear
        fr_txs = '{5, 5, 10, 9};
        fr_rxs = '{0, 2, 5, 22};
        fr_samp = '{16'h00F0, 16'h000F, 16'h1111, 16'hEEEE};
        setup(3, 0, 1);
        run_frame("R9 cmp", 3, 2, 256, 0);
        fr_txs = '{6, 7, 2, 3};
        setup(4, 1, 1);
        run_frame("R9 lin", 4, 9, 256, 0);
        // R5 R6: inputs change mid-frame
        fr_txs = '{1, 8, 15, 29};
        fr_samp = '{16'hBEEF, 16'hCAFE, 16'h0123, 16'h4567};
        setup(2, 0, 0);
        run_frame("R5 midchange", 2, 1, 256, 1);
        // R11: 128-slot frame reaching slot 127
        fr_txs = '{127, 125, 64, 0};
        fr_rxs = '{127, 100, 3, 126};
        fr_samp = '{16'h00B7, 16'h9C3D, 16'h7001, 16'h0080};
        setup(5, 0, 1);
        run_frame("R11 slot127", 5, 3, 1024, 0);
        fr_rxs = '{126, 0, 50, 125};
        fr_txs = '{126, 1, 60, 124};
        setup(1, 1, 0);
        run_frame("R11 lin127", 1, 1, 1024, 0);
        // Random frames
        for (int f = 0; f < 14; f++) begin
            d   = $urandom_range(7, 0);
            fl  = $urandom_range(8, 1);
            ns  = ($urandom_range(1, 0) == 1) ? 24 : 32;
            lin = 1'($urandom);
            rand_slots(ns, lin);
            setup(d, lin, 1'($urandom));
            run_frame($sformatf("R1 R2 rnd%0d", f), d, fl, ns * 8, 1'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule